// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the embedded engine of a 16-bit NOR flash array. It watches each write cycle (a word address and a data word, of which only the low byte carries the command code) and recognises the multi-cycle unlock sequences that turn ordinary writes into operation requests. A recognised operation leaves the block as a single-cycle request pulse that carries the target address, the data word, the sector number and the plane number.

The decoder also holds the state that the command set defines but the array does not: one lockdown bit for each of the 39 sectors, the identification-mode flag, and a sticky single-pulse program mode in which every write becomes a word program. The engine tells the decoder when an embedded program is running and when an erase is suspended. Program and sector-erase requests aimed at locked sectors are never issued, and a new sector erase is refused while an erase is held.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A multi-cycle command begins with low data byte AA at command address 555 followed by 55 at command address 2AA. The command address is address bits 10..0 (bit 11 and above are ignored), and data bits 15..8 are ignored.
- R2: The prefix followed by A0 at 555 and then a write of address X and data D raises req_valid for exactly one cycle, on the clock edge that samples the last write, with req_op=0 (program), req_addr=X, req_data=D and req_plane=X[19:18].
- R3: The prefix, 80 at 555, the prefix again, then 10 at 555 requests chip erase (req_op=1); ending instead with 30 at any address requests sector erase (req_op=2) of the sector holding that address.
- R4: The same six-cycle form ending with 60 at an address sets the lockdown bit of that sector, shown as bit N of lock_map for sector N, and issues no request. Every bit is clear after reset and stays set until the next reset.
- R5: A program or sector-erase request whose sector is locked is not issued; chip erase is still issued with lock_map naming the sectors to skip.
- R6: While erase_held is high, a sector-erase sequence issues no request.
- R7: Outside any sequence, B0 at any address requests erase suspend (req_op=3), and 30 at any address requests erase resume (req_op=4) with req_plane taken from address bits 19..18.
- R8: The prefix followed by 90 at 555 sets id_mode; the prefix followed by F0 at 555, or a lone F0 at any address, clears it. While id_mode is high, id_rd_lock is the lock bit of the sector holding id_rd_addr when that address is word offset 2 inside its sector, and 0 otherwise.
- R9: The prefix followed by C0 at 555 and then a write to an address whose low byte is 80 requests a protection-register lock (req_op=6) only when data bit 1 is 0 and otherwise issues nothing; any other low byte requests a protection-register program (req_op=5).
- R10: The six-cycle form ending with A0 at 555 enters single-pulse mode, in which every write, whatever its data, requests a program (req_op=0) subject to R5; only reset leaves the mode.
- R11: A write made while prog_busy is high has no effect: no request, and no progress through a sequence.
- R12: A write that does not continue the current sequence returns the decoder to idle and is then decoded as if it were the first cycle of a new command.
- R13: Sectors follow a bottom-boot map: addresses below 8000h form sectors 0..7 of 4K words (sector = address bits 14..12); above that, sector = 7 + address bits 19..15, giving sectors 8..38 of 32K words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One write cycle is presented this clock |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Data of the write; bits 7..0 carry command codes |
| prog_busy | input | 1 | Embedded program running; writes are ignored |
| erase_held | input | 1 | An erase is currently suspended |
| id_rd_addr | input | 20 | Address of an identification-mode read |
| req_valid | output | 1 | One-cycle request pulse |
| req_op | output | 3 | Request code: 0 program, 1 chip erase, 2 sector erase, 3 suspend, 4 resume, 5 protection program, 6 protection lock |
| req_addr | output | 20 | Address of the write that completed the request |
| req_data | output | 16 | Data of the write that completed the request |
| req_sector | output | 6 | Sector holding req_addr |
| req_plane | output | 2 | Address bits 19..18 of the completing write |
| id_mode | output | 1 | Identification mode active |
| id_rd_lock | output | 1 | Lock status returned for an identification read |
| lock_map | output | 39 | Lockdown bit of each sector |

## Verification
The assertions watch, on every cycle, that no request appears without a write one cycle earlier or after a cycle with prog_busy high, that no program request ever names a locked sector, that no sector erase follows a cycle with erase_held high, and that lock bits and single-pulse mode never drop outside reset. Only the bench scenarios can show that each sequence decodes to the right code and fields, that every one of the 39 sectors maps correctly, that a broken sequence restarts on the breaking write, and that reset clears locks and leaves single-pulse mode.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int ADDR_W   = 20;
    localparam int DATA_W   = 16;
    localparam int SMALL_SH = 12;
    localparam int BIG_SH   = 15;
    localparam int PLANE_W  = 2;
    localparam int CMD_AW   = 11;
    localparam int N_SMALL  = 1 << (BIG_SH - SMALL_SH);
    localparam int N_BIG    = (1 << (ADDR_W - BIG_SH)) - 1;
    localparam int N_SECT   = N_SMALL + N_BIG;
    localparam int SECT_W   = $clog2(N_SECT);

    localparam logic [CMD_AW-1:0] ADR_FIRST  = 11'h555;
    localparam logic [CMD_AW-1:0] ADR_SECOND = 11'h2AA;

    localparam logic [7:0] CD_KEY1   = 8'hAA;
    localparam logic [7:0] CD_KEY2   = 8'h55;
    localparam logic [7:0] CD_WORD   = 8'hA0;
    localparam logic [7:0] CD_ERASE  = 8'h80;
    localparam logic [7:0] CD_CHIP   = 8'h10;
    localparam logic [7:0] CD_SECT   = 8'h30;
    localparam logic [7:0] CD_LOCK   = 8'h60;
    localparam logic [7:0] CD_HOLD   = 8'hB0;
    localparam logic [7:0] CD_GO     = 8'h30;
    localparam logic [7:0] CD_ID_IN  = 8'h90;
    localparam logic [7:0] CD_ID_OUT = 8'hF0;
    localparam logic [7:0] CD_PREG   = 8'hC0;
    localparam logic [7:0] PREG_LOCK_LOC = 8'h80;

    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_CHIP   = 3'd1,
        OP_SECT   = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RES    = 3'd4,
        OP_PPROG  = 3'd5,
        OP_PLOCK  = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_K1, ST_K2, ST_WORD, ST_PREG, ST_E3, ST_E4, ST_E5
    } seq_e;

    typedef struct packed {
        logic              vld;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:BIG_SH] == '0)
            return SECT_W'(a[BIG_SH-1:SMALL_SH]);
        return SECT_W'(a[ADDR_W-1:BIG_SH]) + SECT_W'(N_SMALL - 1);
    endfunction

    function automatic logic is_lock_word(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:BIG_SH] == '0)
            return a[SMALL_SH-1:0] == SMALL_SH'(2);
        return a[BIG_SH-1:0] == BIG_SH'(2);
    endfunction
endpackage

// File: rtl/fcd_lockmap.sv
module fcd_lockmap
    import fcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [SECT_W-1:0]   set_sect,
    output logic [N_SECT-1:0]   lock_q
);
    for (genvar i = 0; i < N_SECT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                lock_q[i] <= 1'b0;
            else if (set_en && set_sect == SECT_W'(i))
                lock_q[i] <= 1'b1;
        end

        // R4
        lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            lock_q[i] |=> lock_q[i]);
    end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_busy,
    output req_t              raw,
    output logic              lock_set,
    output logic              id_q,
    output logic              sp_q
);
    seq_e st_q, st_n;
    logic id_n, sp_n, brk;
    logic [7:0] d;
    logic is_first, is_second;

    assign d         = wr_data[7:0];
    assign is_first  = wr_addr[CMD_AW-1:0] == ADR_FIRST;
    assign is_second = wr_addr[CMD_AW-1:0] == ADR_SECOND;

    always_comb begin
        st_n     = st_q;
        id_n     = id_q;
        sp_n     = sp_q;
        raw      = '0;
        lock_set = 1'b0;
        brk      = 1'b0;
        if (wr_en && !prog_busy) begin
            raw.addr = wr_addr;
            raw.data = wr_data;
            if (sp_q) begin
                raw.vld = 1'b1;
                raw.op  = OP_PROG;
            end else begin
                st_n = ST_IDLE;
                unique case (st_q)
                    ST_IDLE: brk = 1'b1;
                    ST_K1: begin
                        if (is_second && d == CD_KEY2) st_n = ST_K2;
                        else brk = 1'b1;
                    end
                    ST_K2: begin
                        if (is_first && d == CD_WORD)        st_n = ST_WORD;
                        else if (is_first && d == CD_ERASE)  st_n = ST_E3;
                        else if (is_first && d == CD_PREG)   st_n = ST_PREG;
                        else if (is_first && d == CD_ID_IN)  id_n = 1'b1;
                        else if (is_first && d == CD_ID_OUT) id_n = 1'b0;
                        else brk = 1'b1;
                    end
                    ST_WORD: begin
                        raw.vld = 1'b1;
                        raw.op  = OP_PROG;
                    end
                    ST_PREG: begin
                        if (wr_addr[7:0] == PREG_LOCK_LOC) begin
                            raw.vld = !d[1];
                            raw.op  = OP_PLOCK;
                        end else begin
                            raw.vld = 1'b1;
                            raw.op  = OP_PPROG;
                        end
                    end
                    ST_E3: begin
                        if (is_first && d == CD_KEY1) st_n = ST_E4;
                        else brk = 1'b1;
                    end
                    ST_E4: begin
                        if (is_second && d == CD_KEY2) st_n = ST_E5;
                        else brk = 1'b1;
                    end
                    ST_E5: begin
                        if (is_first && d == CD_CHIP) begin
                            raw.vld = 1'b1;
                            raw.op  = OP_CHIP;
                        end else if (d == CD_SECT) begin
                            raw.vld = 1'b1;
                            raw.op  = OP_SECT;
                        end else if (d == CD_LOCK) begin
                            lock_set = 1'b1;
                        end else if (is_first && d == CD_WORD) begin
                            sp_n = 1'b1;
                        end else begin
                            brk = 1'b1;
                        end
                    end
                    default: brk = 1'b1;
                endcase
                if (brk) begin
                    if (is_first && d == CD_KEY1) begin
                        st_n = ST_K1;
                    end else if (d == CD_HOLD) begin
                        raw.vld = 1'b1;
                        raw.op  = OP_SUSP;
                    end else if (d == CD_GO) begin
                        raw.vld = 1'b1;
                        raw.op  = OP_RES;
                    end else if (d == CD_ID_OUT) begin
                        id_n = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            id_q <= 1'b0;
            sp_q <= 1'b0;
        end else begin
            st_q <= st_n;
            id_q <= id_n;
            sp_q <= sp_n;
        end
    end

    // R10
    sp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sp_q |=> sp_q);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_busy && !sp_q) |=> $stable(st_q));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [19:0]          wr_addr,
    input  logic [15:0]          wr_data,
    input  logic                 prog_busy,
    input  logic                 erase_held,
    input  logic [19:0]          id_rd_addr,
    output logic                 req_valid,
    output logic [2:0]           req_op,
    output logic [19:0]          req_addr,
    output logic [15:0]          req_data,
    output logic [5:0]           req_sector,
    output logic [1:0]           req_plane,
    output logic                 id_mode,
    output logic                 id_rd_lock,
    output logic [38:0]          lock_map
);
    req_t              raw;
    logic              lock_set, sp_mode, blocked;
    logic [SECT_W-1:0] raw_sect;
    logic [N_SECT-1:0] lock_q;
    op_e               op_q;

    fcd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prog_busy (prog_busy),
        .raw       (raw),
        .lock_set  (lock_set),
        .id_q      (id_mode),
        .sp_q      (sp_mode)
    );

    fcd_lockmap u_lock (
        .clk      (clk),
        .rst      (rst),
        .set_en   (lock_set),
        .set_sect (sector_of(wr_addr)),
        .lock_q   (lock_q)
    );

    assign raw_sect = sector_of(raw.addr);
    assign blocked  = (raw.op == OP_PROG && lock_q[raw_sect]) ||
                      (raw.op == OP_SECT && (lock_q[raw_sect] || erase_held));

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid  <= 1'b0;
            op_q       <= OP_PROG;
            req_addr   <= '0;
            req_data   <= '0;
            req_sector <= '0;
            req_plane  <= '0;
        end else begin
            req_valid <= raw.vld && !blocked;
            if (raw.vld) begin
                op_q       <= raw.op;
                req_addr   <= raw.addr;
                req_data   <= raw.data;
                req_sector <= raw_sect;
                req_plane  <= raw.addr[ADDR_W-1 -: PLANE_W];
            end
        end
    end

    assign req_op     = op_q;
    assign lock_map   = lock_q;
    assign id_rd_lock = id_mode && is_lock_word(id_rd_addr) &&
                        lock_q[sector_of(id_rd_addr)];

    // R2
    req_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $past(wr_en));

    // R11
    busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $past(prog_busy) |-> !req_valid);

    // R5
    locked_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_PROG) |-> !lock_map[req_sector]);

    // R6
    held_erase_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_SECT) |-> !$past(erase_held));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        prog_busy = 1'b0;
    logic        erase_held = 1'b0;
    logic [19:0] id_rd_addr = '0;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [19:0] req_addr;
    logic [15:0] req_data;
    logic [5:0]  req_sector;
    logic [1:0]  req_plane;
    logic        id_mode, id_rd_lock;
    logic [38:0] lock_map;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_busy(prog_busy), .erase_held(erase_held), .id_rd_addr(id_rd_addr),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_sector(req_sector), .req_plane(req_plane),
        .id_mode(id_mode), .id_rd_lock(id_rd_lock), .lock_map(lock_map)
    );

    function automatic int sect_of(int a);
        return (a < 32768) ? a / 4096 : 7 + a / 32768;
    endfunction

    function automatic int base_of(int s);
        return (s < 8) ? s * 4096 : (s - 7) * 32768;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 20'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic six(input int a, input logic [15:0] d);
        unlock(); wr(12'h555, 16'h0080); unlock(); wr(a, d);
    endtask

    task automatic exp_req(input string req, input int op, input int a, input logic [15:0] d);
        chk(req, "req_valid", req_valid, 1);
        chk(req, "req_op", req_op, op);
        chk(req, "req_addr", req_addr, a);
        chk(req, "req_data", req_data, d);
        chk(req, "req_sector", req_sector, sect_of(a));
        chk(req, "req_plane", req_plane, (a >> 18) & 3);
    endtask

    task automatic exp_none(input string req);
        chk(req, "req_valid", req_valid, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R4 reset state
        chk("R4", "reset req_valid", req_valid, 0);
        chk("R4", "reset lock_map", lock_map, 0);
        chk("R8", "reset id_mode", id_mode, 0);

        // R2 R13: program sweep over every sector
        for (int s = 0; s < 39; s++) begin
            int a = base_of(s) + (s * 37) % 4096;
            unlock(); wr(12'h555, 16'h00A0); wr(a, 16'(s * 1111 + 7));
            exp_req("R13", 0, a, 16'(s * 1111 + 7));
            if (s == 0) begin
                @(negedge clk);
                chk("R2", "pulse ends", req_valid, 0);
            end
        end

        // R1: A11 ignored, upper data ignored
        wr(12'h555, 16'h12AA); wr(12'hAAA, 16'hFF55); wr(12'hD55, 16'h77A0);
        wr(20'h9ABCD, 16'hCAFE);
        exp_req("R1", 0, 20'h9ABCD, 16'hCAFE);

        // R3
        six(12'h555, 16'h0010);
        exp_req("R3", 1, 12'h555, 16'h0010);
        six(base_of(10) + 5, 16'h0030);
        exp_req("R3", 2, base_of(10) + 5, 16'h0030);

        // R4 lockdown
        six(base_of(3) + 9, 16'h0060);
        exp_none("R4");
        six(base_of(20) + 100, 16'h0060);
        chk("R4", "lock_map", lock_map, (39'd1 << 3) | (39'd1 << 20));

        // R5
        unlock(); wr(12'h555, 16'h00A0); wr(base_of(20) + 4, 16'h1111);
        exp_none("R5");
        six(base_of(3), 16'h0030);
        exp_none("R5");
        six(12'h555, 16'h0010);
        exp_req("R5", 1, 12'h555, 16'h0010);

        // R6
        erase_held = 1'b1;
        six(base_of(10), 16'h0030);
        exp_none("R6");
        erase_held = 1'b0;
        six(base_of(10), 16'h0030);
        exp_req("R6", 2, base_of(10), 16'h0030);

        // R7
        wr(20'h12345, 16'h00B0);
        exp_req("R7", 3, 20'h12345, 16'h00B0);
        wr(20'hC0010, 16'h0030);
        exp_req("R7", 4, 20'hC0010, 16'h0030);
        chk("R7", "plane", req_plane, 3);

        // R8
        unlock(); wr(12'h555, 16'h0090);
        chk("R8", "id entry", id_mode, 1);
        id_rd_addr = 20'(base_of(20) + 2); #1;
        chk("R8", "lock read s20", id_rd_lock, 1);
        id_rd_addr = 20'(base_of(21) + 2); #1;
        chk("R8", "lock read s21", id_rd_lock, 0);
        id_rd_addr = 20'(base_of(3) + 2); #1;
        chk("R8", "lock read s3", id_rd_lock, 1);
        id_rd_addr = 20'(base_of(3) + 3); #1;
        chk("R8", "lock read offset3", id_rd_lock, 0);
        wr(20'h54321, 16'h00F0);
        chk("R8", "single exit", id_mode, 0);
        id_rd_addr = 20'(base_of(20) + 2); #1;
        chk("R8", "lock read outside id", id_rd_lock, 0);
        unlock(); wr(12'h555, 16'h0090);
        unlock(); wr(12'h555, 16'h00F0);
        chk("R8", "prefixed exit", id_mode, 0);

        // R9
        unlock(); wr(12'h555, 16'h00C0); wr(12'h081, 16'hBEEF);
        exp_req("R9", 5, 12'h081, 16'hBEEF);
        unlock(); wr(12'h555, 16'h00C0); wr(12'h080, 16'hFFFD);
        exp_req("R9", 6, 12'h080, 16'hFFFD);
        unlock(); wr(12'h555, 16'h00C0); wr(12'h080, 16'h0002);
        exp_none("R9");

        // R11
        prog_busy = 1'b1;
        wr(20'h00400, 16'h00B0);
        exp_none("R11");
        unlock();
        prog_busy = 1'b0;
        wr(12'h555, 16'h00A0);
        wr(20'h00777, 16'h1234);
        exp_none("R11");

        // R12
        wr(12'h555, 16'h00AA); wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
        wr(12'h555, 16'h00A0); wr(20'h3F000, 16'h4321);
        exp_req("R12", 0, 20'h3F000, 16'h4321);
        wr(12'h555, 16'h00AA); wr(20'h40010, 16'h00B0);
        exp_req("R12", 3, 20'h40010, 16'h00B0);
        unlock(); wr(12'h555, 16'h0080); wr(12'h555, 16'h00AA); wr(12'h555, 16'h0055);
        exp_none("R12");
        wr(20'h00321, 16'h0042);
        exp_none("R12");

        // R10 single-pulse, every data byte
        six(12'h555, 16'h00A0);
        exp_none("R10");
        for (int v = 0; v < 256; v++) begin
            wr(base_of(30) + v, {8'h5A, 8'(v)});
            exp_req("R10", 0, base_of(30) + v, {8'h5A, 8'(v)});
        end
        wr(base_of(20) + 1, 16'h00B0);
        exp_none("R10");

        // R4 R10 reset clears
        do_reset();
        chk("R4", "lock_map after reset", lock_map, 0);
        wr(20'h00010, 16'h00B0);
        exp_req("R10", 3, 20'h00010, 16'h00B0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule